// File: doc/BRIEF.md
# Lane Control-Code Packet Framer

This block sits behind a byte-aligned receive lane. Each cycle that its input is valid, it takes one 32-bit word of four 8-bit symbols, together with one flag per symbol that marks the symbol as a control character. A state machine follows the link's training sequence. First comes a run of sync words, then a run of idle words, and only then may a packet open. All control sequences are four symbols long and occupy one whole word.

Once a start word has been seen, the block forwards every plain data word with a one-cycle valid strobe. It drops pad words silently. It closes the packet when the end word arrives. A packet-enable output is high for exactly the cycles in which the framer is inside a packet. A 4-bit state indicator lets a downstream merger, or a debug path, see where each lane stands. If any stray control symbol appears inside a packet, the packet is abandoned and the lane falls back to its untrained state.

Top module: `lane_packet_framer`

## Requirements
- R1: While reset is held, and in the first cycle after it, linkState is 0, outValid is 0 and pktEn is 0.
- R2: In state 0 (untrained), a sync word moves linkState to 1 on the next cycle. A sync word has symbol 0 = 0xBC with its control flag set, and symbols 1..3 = 0x4A with their flags clear, so ctrl = 4'b0001. Any other valid word, including a start word, leaves linkState at 0 and forwards nothing.
- R3: In state 1 (sync seen), a sync word keeps linkState at 1. An idle word moves it to 2. An idle word is four 0x00 symbols with ctrl = 4'b0000. Any other valid word returns linkState to 0.
- R4: In state 2 (idle seen), an idle word keeps linkState at 2, a sync word moves it to 1, and a start word moves it to 3. A start word is, from symbol 0 to symbol 3, 0xBC 0xFB 0x5C 0xFB with ctrl = 4'b1111. Any other valid word returns linkState to 0.
- R5: pktEn is 1 exactly when linkState is 3. outValid is never 1 while pktEn is 0. The start word itself is never forwarded.
- R6: In state 3, a valid word whose ctrl is 4'b0000 appears unchanged on outData, with outValid = 1, one cycle after it is presented. Symbol 0 is bits [7:0]. This holds for every data value, an all-zero word included.
- R7: In state 3, a pad word keeps linkState at 3 and produces no outValid. A pad word is 0xF7 0x9C 0xDC 0x7C with ctrl = 4'b1111.
- R8: In state 3, an end word moves linkState to 2 and drops pktEn on the next cycle, and it is not forwarded. An end word is 0xBC 0xFD 0xFE 0xFD with ctrl = 4'b1111.
- R9: In state 3, any other valid word with a ctrl bit set moves linkState to 0, drops pktEn and forwards nothing.
- R10: A cycle with inValid = 0 leaves linkState and pktEn unchanged and gives outValid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane word clock |
| arstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word qualifier |
| inData | input | 32 | Four received symbols, symbol 0 in bits [7:0] |
| inCtrl | input | 4 | Per-symbol control flag, bit i for symbol i |
| outData | output | 32 | Forwarded packet word |
| outValid | output | 1 | outData holds a forwarded word this cycle |
| pktEn | output | 1 | High while inside a packet |
| linkState | output | 4 | 0 untrained, 1 sync seen, 2 idle seen, 3 in packet |

## Verification
The embedded properties check the legal shape of the state graph on every cycle. They confirm that the untrained state exits only to the sync state, that a packet is entered only from the idle state and left only for the idle or untrained state, and that the state holds across invalid cycles. They also check that pktEn tracks the in-packet state and that no word is forwarded outside a packet. Only the scenarios can show which word causes each transition. The same holds for whether pad, start and end words stay out of the stream, and whether forwarded data arrives intact and in order. A scoreboard queue covers the ordering, and per-word checks of state and strobe cover the rest.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

  localparam int SYM_W   = 8;
  localparam int SYMS    = 4;
  localparam int WORD_W  = SYM_W * SYMS;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    LS_UNTRAINED = 4'd0,
    LS_SYNC      = 4'd1,
    LS_IDLE      = 4'd2,
    LS_PACKET    = 4'd3
  } linkState_t;

  typedef struct packed {
    logic isSync;
    logic isIdle;
    logic isStart;
    logic isEnd;
    logic isPad;
    logic anyCtrl;
  } wordClass_t;

  typedef struct packed {
    logic fwd;
    logic pktOn;
  } ctrlStrobe_t;

  // Patterns: symbol 0 in the low byte
  localparam logic [WORD_W-1:0] PAT_SYNC  = 32'h4A4A_4ABC;
  localparam logic [SYMS-1:0]   FLG_SYNC  = 4'b0001;
  localparam logic [WORD_W-1:0] PAT_IDLE  = 32'h0000_0000;
  localparam logic [SYMS-1:0]   FLG_IDLE  = 4'b0000;
  localparam logic [WORD_W-1:0] PAT_START = 32'hFB5C_FBBC;
  localparam logic [WORD_W-1:0] PAT_END   = 32'hFDFE_FDBC;
  localparam logic [WORD_W-1:0] PAT_PAD   = 32'h7CDC_9CF7;
  localparam logic [SYMS-1:0]   FLG_ALLK  = 4'b1111;

endpackage

// File: rtl/lpf_word_classifier.sv
module lpf_word_classifier
  import lpf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [SYMS-1:0]   flags,
  output wordClass_t        cls
);

  localparam int NPAT = 5;

  logic [WORD_W-1:0] patWord [NPAT];
  logic [SYMS-1:0]   patFlag [NPAT];
  logic [NPAT-1:0]   hit;

  assign patWord[0] = PAT_SYNC;  assign patFlag[0] = FLG_SYNC;
  assign patWord[1] = PAT_IDLE;  assign patFlag[1] = FLG_IDLE;
  assign patWord[2] = PAT_START; assign patFlag[2] = FLG_ALLK;
  assign patWord[3] = PAT_END;   assign patFlag[3] = FLG_ALLK;
  assign patWord[4] = PAT_PAD;   assign patFlag[4] = FLG_ALLK;

  for (genvar p = 0; p < NPAT; p++) begin : gPat
    logic [SYMS-1:0] symHit;
    for (genvar s = 0; s < SYMS; s++) begin : gSym
      assign symHit[s] = (word[s*SYM_W +: SYM_W] == patWord[p][s*SYM_W +: SYM_W])
                       && (flags[s] == patFlag[p][s]);
    end
    assign hit[p] = &symHit;
  end

  always_comb begin
    cls.isSync  = hit[0];
    cls.isIdle  = hit[1];
    cls.isStart = hit[2];
    cls.isEnd   = hit[3];
    cls.isPad   = hit[4];
    cls.anyCtrl = |flags;
  end

endmodule

// File: rtl/lpf_frame_ctrl.sv
module lpf_frame_ctrl
  import lpf_pkg::*;
(
  input  logic        clk,
  input  logic        arstN,
  input  logic        inValid,
  input  wordClass_t  cls,
  output linkState_t  state,
  output ctrlStrobe_t strobe
);

  linkState_t nextState;

  always_comb begin
    nextState  = state;
    strobe.fwd = 1'b0;
    if (inValid) begin
      unique case (state)
        LS_UNTRAINED: begin
          if (cls.isSync) nextState = LS_SYNC;
        end
        LS_SYNC: begin
          if (cls.isSync)      nextState = LS_SYNC;
          else if (cls.isIdle) nextState = LS_IDLE;
          else                 nextState = LS_UNTRAINED;
        end
        LS_IDLE: begin
          if (cls.isIdle)       nextState = LS_IDLE;
          else if (cls.isStart) nextState = LS_PACKET;
          else if (cls.isSync)  nextState = LS_SYNC;
          else                  nextState = LS_UNTRAINED;
        end
        LS_PACKET: begin
          if (cls.isEnd)        nextState = LS_IDLE;
          else if (cls.isPad)   nextState = LS_PACKET;
          else if (cls.anyCtrl) nextState = LS_UNTRAINED;
          else begin
            nextState  = LS_PACKET;
            strobe.fwd = 1'b1;
          end
        end
        default: nextState = LS_UNTRAINED;
      endcase
    end
  end

  assign strobe.pktOn = (nextState == LS_PACKET);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= LS_UNTRAINED;
    else        state <= nextState;
  end

  AST_UNTRAINED_EXIT: assert property (@(posedge clk) disable iff (!arstN)
    ($past(state) == LS_UNTRAINED && state != LS_UNTRAINED) |-> state == LS_SYNC); // R2

  AST_PACKET_ENTRY: assert property (@(posedge clk) disable iff (!arstN)
    (state == LS_PACKET && $past(state) != LS_PACKET) |-> $past(state) == LS_IDLE); // R4

  AST_PACKET_LEAVE: assert property (@(posedge clk) disable iff (!arstN)
    ($past(state) == LS_PACKET && state != LS_PACKET)
      |-> (state == LS_IDLE || state == LS_UNTRAINED)); // R8

  AST_HOLD_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!arstN)
    !inValid |=> $stable(state)); // R10

endmodule

// File: rtl/lpf_frame_datapath.sv
module lpf_frame_datapath
  import lpf_pkg::*;
(
  input  logic              clk,
  input  logic              arstN,
  input  logic [WORD_W-1:0] inData,
  input  ctrlStrobe_t       strobe,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              pktEn
);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      outData  <= '0;
      outValid <= 1'b0;
      pktEn    <= 1'b0;
    end else begin
      outValid <= strobe.fwd;
      pktEn    <= strobe.pktOn;
      if (strobe.fwd) outData <= inData;
    end
  end

  AST_VALID_INSIDE_PKT: assert property (@(posedge clk) disable iff (!arstN)
    outValid |-> pktEn); // R5

  AST_DATA_STABLE_GAP: assert property (@(posedge clk) disable iff (!arstN)
    !outValid |-> $stable(outData) || $past(outValid)); // R6

endmodule

// File: rtl/lane_packet_framer.sv
module lane_packet_framer
  import lpf_pkg::*;
(
  input  logic        clk,
  input  logic        arstN,
  input  logic        inValid,
  input  logic [31:0] inData,
  input  logic [3:0]  inCtrl,
  output logic [31:0] outData,
  output logic        outValid,
  output logic        pktEn,
  output logic [3:0]  linkState
);

  wordClass_t  cls;
  linkState_t  state;
  ctrlStrobe_t strobe;

  lpf_word_classifier uClassify (
    .word  (inData),
    .flags (inCtrl),
    .cls   (cls)
  );

  lpf_frame_ctrl uCtrl (
    .clk     (clk),
    .arstN   (arstN),
    .inValid (inValid),
    .cls     (cls),
    .state   (state),
    .strobe  (strobe)
  );

  lpf_frame_datapath uData (
    .clk      (clk),
    .arstN    (arstN),
    .inData   (inData),
    .strobe   (strobe),
    .outData  (outData),
    .outValid (outValid),
    .pktEn    (pktEn)
  );

  assign linkState = state;

  AST_PKTEN_MATCHES_STATE: assert property (@(posedge clk) disable iff (!arstN)
    pktEn == (linkState == 4'd3)); // R5

endmodule

// File: tb/tb_lane_packet_framer.sv
module tb_lane_packet_framer;

  logic        clk = 1'b0;
  logic        arstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [3:0]  inCtrl = '0;
  logic [31:0] outData;
  logic        outValid;
  logic        pktEn;
  logic [3:0]  linkState;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] expQ [$];
  bit finished = 0;

  localparam logic [31:0] W_SYNC  = 32'h4A4A_4ABC;
  localparam logic [31:0] W_IDLE  = 32'h0000_0000;
  localparam logic [31:0] W_START = 32'hFB5C_FBBC;
  localparam logic [31:0] W_END   = 32'hFDFE_FDBC;
  localparam logic [31:0] W_PAD   = 32'h7CDC_9CF7;

  always #2 clk = ~clk;

  lane_packet_framer dut (
    .clk(clk), .arstN(arstN), .inValid(inValid), .inData(inData),
    .inCtrl(inCtrl), .outData(outData), .outValid(outValid),
    .pktEn(pktEn), .linkState(linkState)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: presents one word, predicts the state and strobe a cycle later
  task automatic sendWord(logic vld, logic [31:0] d, logic [3:0] c,
                          logic [3:0] expState, bit expFwd, string tag);
    @(negedge clk);
    inValid = vld; inData = d; inCtrl = c;
    if (expFwd) expQ.push_back(d);
    @(posedge clk);
    #1;
    check({tag, " state"}, {28'd0, linkState}, {28'd0, expState});
    check({tag, " pktEn"}, {31'd0, pktEn}, {31'd0, expState == 4'd3});
    check({tag, " outValid"}, {31'd0, outValid}, {31'd0, expFwd});
  endtask

  // Monitor: every forwarded word must match the queue head, in order (R6)
  always @(posedge clk) begin
    #1;
    if (arstN && outValid) begin
      if (expQ.size() == 0) check("R6 unexpected word", outData, 32'hxxxx_xxxx);
      else check("R6 forwarded data", outData, expQ.pop_front());
    end
  end

  initial begin
    #(4 * 5000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", {28'd0, linkState}, 32'd0);
    check("R1 reset outValid", {31'd0, outValid}, 32'd0);
    check("R1 reset pktEn", {31'd0, pktEn}, 32'd0);
    @(negedge clk); arstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {28'd0, linkState}, 32'd0);

    // Untrained state ignores everything but sync
    sendWord(1, W_START, 4'hF, 4'd0, 0, "R2 start ignored");
    sendWord(1, W_IDLE, 4'h0, 4'd0, 0, "R2 idle ignored");
    sendWord(1, 32'h1234_5678, 4'h0, 4'd0, 0, "R2 data ignored");
    sendWord(1, W_SYNC, 4'h1, 4'd1, 0, "R2 sync enters");
    sendWord(1, W_SYNC, 4'h1, 4'd1, 0, "R3 sync holds");
    sendWord(1, W_IDLE, 4'h0, 4'd2, 0, "R3 idle advances");
    sendWord(1, W_IDLE, 4'h0, 4'd2, 0, "R4 idle holds");
    sendWord(1, W_START, 4'hF, 4'd3, 0, "R4 R5 start opens");
    sendWord(1, 32'hDEAD_BEEF, 4'h0, 4'd3, 1, "R6 data one");
    sendWord(1, 32'h0000_0000, 4'h0, 4'd3, 1, "R6 zero data");
    sendWord(1, W_PAD, 4'hF, 4'd3, 0, "R7 pad dropped");
    sendWord(0, 32'hAAAA_5555, 4'h0, 4'd3, 0, "R10 invalid gap");
    sendWord(1, 32'hCAFE_F00D, 4'h0, 4'd3, 1, "R6 data after pad");
    sendWord(1, W_PAD, 4'hF, 4'd3, 0, "R7 second pad");
    sendWord(1, W_END, 4'hF, 4'd2, 0, "R8 end closes");
    sendWord(0, W_START, 4'hF, 4'd2, 0, "R10 invalid start ignored");
    sendWord(1, W_SYNC, 4'h1, 4'd1, 0, "R4 sync from idle");
    sendWord(1, 32'h0102_0304, 4'h0, 4'd0, 0, "R3 other drops");
    sendWord(1, W_SYNC, 4'h1, 4'd1, 0, "R2 resync");
    sendWord(1, W_IDLE, 4'h0, 4'd2, 0, "R3 idle again");
    sendWord(1, W_END, 4'hF, 4'd0, 0, "R4 other drops");
    sendWord(1, W_SYNC, 4'h1, 4'd1, 0, "R2 resync two");
    sendWord(1, W_IDLE, 4'h0, 4'd2, 0, "R3 idle three");
    sendWord(1, W_START, 4'hF, 4'd3, 0, "R5 reopen");
    sendWord(1, 32'h7654_3210, 4'h0, 4'd3, 1, "R6 data two");
    sendWord(1, 32'h1C00_0000, 4'h8, 4'd0, 0, "R9 stray control");
    sendWord(1, 32'h5555_AAAA, 4'h0, 4'd0, 0, "R9 data after abort");
    sendWord(0, W_IDLE, 4'h0, 4'd0, 0, "R10 idle cycle");

    check("R6 queue drained", expQ.size(), 32'd0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule